// File: doc/BRIEF.md
# Parity-Protected Direct-Mapped Cache Store

This block holds the tag and data arrays of a small direct-mapped cache. There are 128 lines of four 32-bit words each. Every stored tag and every stored data word is kept together with four interleaved parity bits. On each lookup the block reads the tag entry and the addressed data word. In the following cycle it compares the tag and checks both parities in parallel, then reports hit or miss. The error check adds no cycle to a hit.

Any parity mismatch turns the response into a miss. The block then drops every valid bit of the line and raises a restart request, so the processor repeats the access from memory. Each word has its own valid bit, so a line can be partly filled. Two saturating counters record detected tag errors and data errors for diagnostics. A fault-injection input flips chosen stored bits, so that upsets can be provoked on purpose.

Top module: `cpar_cache_store`

## Requirements
- R1: Each stored tag and data word carries four parity bits. Parity bit i is the XOR of the word bits whose index modulo 4 equals i. The parity is computed when the word is filled, and a word that was filled correctly never reports an error.
- R2: Address fields: bits [1:0] are ignored, bits [3:2] select the word, bits [10:4] select the line and bits [31:11] form the tag. The results appear with `rsp_valid` in the cycle after `lk_valid` is sampled.
- R3: A lookup whose tag matches a valid word with good parity reports `rsp_hit` and returns the filled data on `rsp_data`.
- R4: A fill sets the valid bit of its own word. If the line already holds the same tag, the other valid bits are kept. If the tag differs, only the filled word is left valid.
- R5: A tag parity mismatch on a line that has any valid word gives a miss with `rsp_restart` and `rsp_tag_err`, and invalidates the whole line.
- R6: A data parity mismatch on a valid word whose tag matches gives a miss with `rsp_restart` and `rsp_data_err`, and invalidates the whole line.
- R7: Up to four flipped bits in one stored word are detected when each lies in a different parity group. This includes flips in the parity bits themselves.
- R8: The tag-error and data-error counters are separate. Each rises by one for every response that reports its kind of error, and the new value is visible in the cycle after that response.
- R9: The counters stop at 255. `cnt_clr` zeroes both counters on the next edge and takes priority over an increment.
- R10: A lookup of a line, presented in the response cycle of a restart on that same line, finds the line invalid.
- R11: After reset, `rsp_valid` is low, both counters read zero and every word is invalid.
- R12: A tag mismatch or an invalid word gives a plain miss, with no restart and no error flag.
- R13: `inj_en` XORs `inj_mask` into one stored entry. `inj_tag` = 1 selects the tag entry: mask bits [20:0] are the tag and [24:21] its parity. `inj_tag` = 0 selects the data entry: mask bits [31:0] are the data and [35:32] its parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| fill_en | input | 1 | Fill write strobe |
| fill_addr | input | 32 | Fill byte address |
| fill_data | input | 32 | Fill data word |
| inj_en | input | 1 | Fault-injection strobe |
| inj_tag | input | 1 | 1: inject into tag entry, 0: into data entry |
| inj_addr | input | 32 | Address of the entry to corrupt |
| inj_mask | input | 36 | XOR mask applied to the stored entry |
| cnt_clr | input | 1 | Clear both error counters |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_restart | output | 1 | Parity error, access must be retried |
| rsp_data | output | 32 | Read data, meaningful on hit |
| rsp_tag_err | output | 1 | Tag parity error detected |
| rsp_data_err | output | 1 | Data parity error detected |
| tag_err_cnt | output | 8 | Saturating tag error count |
| data_err_cnt | output | 8 | Saturating data error count |

## Verification
Some properties are checked on every cycle:
- a response follows each request by exactly one cycle;
- a fill leaves its word valid;
- a flush empties the line;
- a lookup that follows a restart on the same line cannot hit;
- the counters step by one, hold at their ceiling and obey clear.

Other behaviour only the bench's scenarios can show: that the parity groups really catch four spread flips, that partial lines and tag replacement keep the right words, and that the data returned on a hit is the data that was filled.

// File: rtl/cpar_pkg.sv
package cpar_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int PAR_W  = 4;
    localparam int IDX_W  = 7;
    localparam int WOFF_W = 2;
    localparam int BOFF_W = 2;
    localparam int CNT_W  = 8;

    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
    localparam int LINES  = 1 << IDX_W;
    localparam int WORDS  = 1 << WOFF_W;
    localparam int DIDX_W = IDX_W + WOFF_W;
    localparam int DEPTH  = 1 << DIDX_W;
    localparam int TENT_W = TAG_W + PAR_W;
    localparam int DENT_W = DATA_W + PAR_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WOFF_W-1:0] woff_t;
    typedef logic [DIDX_W-1:0] didx_t;
    typedef logic [WORDS-1:0]  vmask_t;

    typedef struct packed {
        tag_t                tag;
        idx_t                idx;
        woff_t               word;
        logic [BOFF_W-1:0]   boff;
    } addr_t;

    typedef struct packed {
        logic [PAR_W-1:0] par;
        tag_t             tag;
    } tent_t;

    typedef struct packed {
        logic [PAR_W-1:0]  par;
        logic [DATA_W-1:0] data;
    } dent_t;

    typedef struct packed {
        logic hit;
        logic tag_err;
        logic data_err;
    } verdict_t;

    // Interleaved parity: group g collects every bit j with j mod PAR_W == g.
    function automatic logic [PAR_W-1:0] ilv_par(input logic [DATA_W-1:0] v, input int n);
        logic [PAR_W-1:0] r;
        r = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (j < n) r[j % PAR_W] = r[j % PAR_W] ^ v[j];
        end
        return r;
    endfunction

    function automatic tent_t make_tent(input tag_t t);
        tent_t e;
        e.tag = t;
        e.par = ilv_par(DATA_W'(t), TAG_W);
        return e;
    endfunction

    function automatic dent_t make_dent(input logic [DATA_W-1:0] d);
        dent_t e;
        e.data = d;
        e.par  = ilv_par(d, DATA_W);
        return e;
    endfunction
endpackage

// File: rtl/cpar_tag_store.sv
module cpar_tag_store
    import cpar_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_en,
    input  idx_t   rd_idx,
    input  logic   flush_en,
    input  idx_t   flush_idx,
    input  logic   fill_en,
    input  idx_t   fill_idx,
    input  woff_t  fill_word,
    input  tag_t   fill_tag,
    input  logic   inj_en,
    input  idx_t   inj_idx,
    input  tent_t  inj_mask,
    output tent_t  rd_entry,
    output vmask_t rd_valid
);
    tent_t  tag_q [LINES];
    vmask_t vld_q [LINES];

    vmask_t fill_base;
    vmask_t fill_bit;
    vmask_t fill_next;
    logic   fill_same;

    // A fill to a line being flushed this edge starts from an empty line.
    always_comb begin
        fill_base = (flush_en && flush_idx == fill_idx) ? '0 : vld_q[fill_idx];
        fill_same = (tag_q[fill_idx].tag == fill_tag);
        fill_bit  = '0;
        fill_bit[fill_word] = 1'b1;
        fill_next = (fill_same ? fill_base : '0) | fill_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
        end else begin
            if (flush_en) vld_q[flush_idx] <= '0;
            if (fill_en)  vld_q[fill_idx]  <= fill_next;
        end
    end

    always_ff @(posedge clk) begin
        if (inj_en)  tag_q[inj_idx]  <= tag_q[inj_idx] ^ inj_mask;
        if (fill_en) tag_q[fill_idx] <= make_tent(fill_tag);
    end

    // Read port; a flush landing this edge on the same line is forwarded.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= '0;
        end else if (rd_en) begin
            rd_valid <= (flush_en && flush_idx == rd_idx) ? '0 : vld_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_entry <= tag_q[rd_idx];
    end

    p_fill_sets_word_r4: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> vld_q[$past(fill_idx)][$past(fill_word)]);

    p_flush_empties_line_r6: assert property (@(posedge clk) disable iff (rst)
        (flush_en && !(fill_en && fill_idx == flush_idx)) |=> (vld_q[$past(flush_idx)] == '0));
endmodule

// File: rtl/cpar_data_store.sv
module cpar_data_store
    import cpar_pkg::*;
(
    input  logic              clk,
    input  logic              rd_en,
    input  didx_t             rd_addr,
    input  logic              fill_en,
    input  didx_t             fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inj_en,
    input  didx_t             inj_addr,
    input  dent_t             inj_mask,
    output dent_t             rd_entry
);
    dent_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (inj_en)  mem_q[inj_addr]  <= mem_q[inj_addr] ^ inj_mask;
        if (fill_en) mem_q[fill_addr] <= make_dent(fill_data);
        if (rd_en)   rd_entry         <= mem_q[rd_addr];
    end
endmodule

// File: rtl/cpar_lookup_check.sv
module cpar_lookup_check
    import cpar_pkg::*;
(
    input  tag_t     req_tag,
    input  woff_t    req_word,
    input  tent_t    tent,
    input  vmask_t   line_valid,
    input  dent_t    dent,
    output verdict_t verdict
);
    logic line_live;
    logic tag_bad;
    logic tag_match;
    logic word_live;
    logic data_bad;

    // Parity checks run beside the tag compare, all in the same cycle.
    always_comb begin
        line_live = |line_valid;
        word_live = line_valid[req_word];
        tag_bad   = (ilv_par(DATA_W'(tent.tag), TAG_W) != tent.par);
        tag_match = (tent.tag == req_tag);
        data_bad  = (ilv_par(dent.data, DATA_W) != dent.par);

        verdict.tag_err  = line_live && tag_bad;
        verdict.data_err = line_live && !tag_bad && tag_match && word_live && data_bad;
        verdict.hit      = line_live && !tag_bad && tag_match && word_live && !data_bad;
    end
endmodule

// File: rtl/cpar_sat_counter.sv
module cpar_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)                cnt <= '0;
        else if (inc && cnt != CMAX)   cnt <= cnt + 1'b1;
    end

    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));

    p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == CMAX && !clr) |=> (cnt == CMAX));

    p_count_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/cpar_cache_store.sv
module cpar_cache_store
    import cpar_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lk_valid,
    input  logic [ADDR_W-1:0]       lk_addr,
    input  logic                    fill_en,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [DATA_W-1:0]       fill_data,
    input  logic                    inj_en,
    input  logic                    inj_tag,
    input  logic [ADDR_W-1:0]       inj_addr,
    input  logic [DENT_W-1:0]       inj_mask,
    input  logic                    cnt_clr,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_restart,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    rsp_tag_err,
    output logic                    rsp_data_err,
    output logic [CNT_W-1:0]        tag_err_cnt,
    output logic [CNT_W-1:0]        data_err_cnt
);
    addr_t lk_a, fill_a, inj_a;
    assign lk_a   = addr_t'(lk_addr);
    assign fill_a = addr_t'(fill_addr);
    assign inj_a  = addr_t'(inj_addr);

    logic unused_boff;
    assign unused_boff = ^{lk_a.boff, fill_a.boff, inj_a.boff};

    // Request stage
    logic  req_q;
    tag_t  req_tag_q;
    idx_t  req_idx_q;
    woff_t req_word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            req_tag_q  <= '0;
            req_idx_q  <= '0;
            req_word_q <= '0;
        end else begin
            req_q <= lk_valid;
            if (lk_valid) begin
                req_tag_q  <= lk_a.tag;
                req_idx_q  <= lk_a.idx;
                req_word_q <= lk_a.word;
            end
        end
    end

    tent_t    tent;
    vmask_t   line_valid;
    dent_t    dent;
    verdict_t verdict;
    logic     flush_en;

    assign flush_en = req_q && (verdict.tag_err || verdict.data_err);

    cpar_tag_store u_tags (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (lk_valid),
        .rd_idx    (lk_a.idx),
        .flush_en  (flush_en),
        .flush_idx (req_idx_q),
        .fill_en   (fill_en),
        .fill_idx  (fill_a.idx),
        .fill_word (fill_a.word),
        .fill_tag  (fill_a.tag),
        .inj_en    (inj_en && inj_tag),
        .inj_idx   (inj_a.idx),
        .inj_mask  (tent_t'(inj_mask[TENT_W-1:0])),
        .rd_entry  (tent),
        .rd_valid  (line_valid)
    );

    cpar_data_store u_data (
        .clk       (clk),
        .rd_en     (lk_valid),
        .rd_addr   ({lk_a.idx, lk_a.word}),
        .fill_en   (fill_en),
        .fill_addr ({fill_a.idx, fill_a.word}),
        .fill_data (fill_data),
        .inj_en    (inj_en && !inj_tag),
        .inj_addr  ({inj_a.idx, inj_a.word}),
        .inj_mask  (dent_t'(inj_mask)),
        .rd_entry  (dent)
    );

    cpar_lookup_check u_check (
        .req_tag    (req_tag_q),
        .req_word   (req_word_q),
        .tent       (tent),
        .line_valid (line_valid),
        .dent       (dent),
        .verdict    (verdict)
    );

    assign rsp_valid    = req_q;
    assign rsp_hit      = req_q && verdict.hit;
    assign rsp_tag_err  = req_q && verdict.tag_err;
    assign rsp_data_err = req_q && verdict.data_err;
    assign rsp_restart  = flush_en;
    assign rsp_data     = dent.data;

    cpar_sat_counter #(.W(CNT_W)) u_tag_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (rsp_tag_err),
        .cnt (tag_err_cnt)
    );

    cpar_sat_counter #(.W(CNT_W)) u_data_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .inc (rsp_data_err),
        .cnt (data_err_cnt)
    );

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(lk_valid)));

    p_no_hit_after_flush_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_restart && lk_valid && lk_a.idx == req_idx_q && !fill_en) |=> (!rsp_hit && !rsp_restart));
endmodule

// File: tb/cpar_cache_store_test.sv
module cpar_cache_store_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        lk_valid, fill_en, inj_en, inj_tag, cnt_clr;
    logic [31:0] lk_addr, fill_addr, fill_data, inj_addr;
    logic [35:0] inj_mask;
    logic        rsp_valid, rsp_hit, rsp_restart, rsp_tag_err, rsp_data_err;
    logic [31:0] rsp_data;
    logic [7:0]  tag_err_cnt, data_err_cnt;

    cpar_cache_store uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .inj_en(inj_en), .inj_tag(inj_tag), .inj_addr(inj_addr), .inj_mask(inj_mask),
        .cnt_clr(cnt_clr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_restart(rsp_restart), .rsp_data(rsp_data), .rsp_tag_err(rsp_tag_err),
        .rsp_data_err(rsp_data_err), .tag_err_cnt(tag_err_cnt), .data_err_cnt(data_err_cnt)
    );

    typedef struct {
        logic [3:0]  flags;   // hit, restart, tag_err, data_err
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [24:0] m_tag [128];
    logic [35:0] m_data[512];
    logic [3:0]  m_vld [128];
    int m_tcnt = 0;
    int m_dcnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_par(input logic [31:0] w, input int n);
        logic [3:0] r = 4'b0;
        for (int j = 0; j < n; j++) r[j % 4] = r[j % 4] ^ w[j];
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic [20:0] t, input int idx, input int w);
        return {t, 7'(idx), 2'(w), 2'b00};
    endfunction

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pops the scoreboard on each response
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R2", "response without request", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk({rsp_hit, rsp_restart, rsp_tag_err, rsp_data_err} == e.flags, e.req,
                        "flags hit/restart/terr/derr",
                        {60'b0, rsp_hit, rsp_restart, rsp_tag_err, rsp_data_err}, {60'b0, e.flags});
                    if (e.flags[3])
                        chk(rsp_data == e.data, e.req, "hit data", {32'b0, rsp_data}, {32'b0, e.data});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic do_fill(input logic [31:0] a, input logic [31:0] d);
        int idx = int'(a[10:4]);
        int w = int'(a[3:2]);
        logic [3:0] base = m_vld[idx];
        logic [3:0] bit1 = 4'b0001 << w;
        if (m_tag[idx][20:0] === a[31:11] && base != 0) m_vld[idx] = base | bit1;
        else m_vld[idx] = bit1;
        m_tag[idx] = {ref_par({11'b0, a[31:11]}, 21), a[31:11]};
        m_data[{a[10:4], a[3:2]}] = {ref_par(d, 32), d};
        fill_en = 1'b1; fill_addr = a; fill_data = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_inject(input bit is_tag, input logic [31:0] a, input logic [35:0] m);
        if (is_tag) m_tag[a[10:4]] = m_tag[a[10:4]] ^ m[24:0];
        else m_data[{a[10:4], a[3:2]}] = m_data[{a[10:4], a[3:2]}] ^ m;
        inj_en = 1'b1; inj_tag = is_tag; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] a, input string req);
        exp_t e;
        int idx = int'(a[10:4]);
        logic [24:0] te = m_tag[idx];
        logic [35:0] de = m_data[{a[10:4], a[3:2]}];
        bit live = (m_vld[idx] != 0);
        bit terr = live && (ref_par({11'b0, te[20:0]}, 21) !== te[24:21]);
        bit match = live && (te[20:0] === a[31:11]);
        bit wv = m_vld[idx][a[3:2]];
        bit derr = !terr && match && wv && (ref_par(de[31:0], 32) !== de[35:32]);
        bit hit = match && wv && !terr && !derr;
        e.flags = {hit, terr || derr, terr, derr};
        e.data = de[31:0];
        e.req = req;
        sbq.push_back(e);
        if (terr || derr) m_vld[idx] = 4'b0;
        if (terr && m_tcnt < 255) m_tcnt++;
        if (derr && m_dcnt < 255) m_dcnt++;
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic check_counts(input string req);
        @(negedge clk);
        chk(tag_err_cnt == 8'(m_tcnt), req, "tag error count", {56'b0, tag_err_cnt}, 64'(m_tcnt));
        chk(data_err_cnt == 8'(m_dcnt), req, "data error count", {56'b0, data_err_cnt}, 64'(m_dcnt));
    endtask

    task automatic do_clear();
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        m_tcnt = 0;
        m_dcnt = 0;
    endtask

    localparam logic [20:0] TA = 21'h0ABCD;
    localparam logic [20:0] TB = 21'h15432;

    initial begin
        for (int i = 0; i < 128; i++) m_vld[i] = 4'b0;
        rst = 1'b1; lk_valid = 0; fill_en = 0; inj_en = 0; inj_tag = 0; cnt_clr = 0;
        lk_addr = 0; fill_addr = 0; fill_data = 0; inj_addr = 0; inj_mask = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", {63'b0, rsp_valid}, 0);
        chk(tag_err_cnt == 0 && data_err_cnt == 0, "R11", "counters after reset",
            {48'b0, tag_err_cnt, data_err_cnt}, 0);
        do_lookup(mk(TA, 3, 0), "R11");

        // R1 R3: fill a full line with varied patterns and hit each word
        do_fill(mk(TA, 3, 0), 32'hDEADBEEF);
        do_fill(mk(TA, 3, 1), 32'h00000000);
        do_fill(mk(TA, 3, 2), 32'hFFFFFFFF);
        do_fill(mk(TA, 3, 3), 32'h12345678);
        for (int w = 0; w < 4; w++) do_lookup(mk(TA, 3, w), "R3");
        // R2: byte offset bits ignored
        do_lookup(mk(TA, 3, 3) | 32'h3, "R2");
        // R12: tag mismatch on a valid line
        do_lookup(mk(TB, 3, 0), "R12");

        // R4: partial line, then tag replacement
        do_fill(mk(TA, 20, 1), 32'hCAFE0001);
        do_lookup(mk(TA, 20, 1), "R4");
        do_lookup(mk(TA, 20, 2), "R4");
        do_fill(mk(TA, 20, 2), 32'hCAFE0002);
        do_lookup(mk(TA, 20, 1), "R4");
        do_fill(mk(TB, 20, 0), 32'hBEEF0000);
        do_lookup(mk(TA, 20, 1), "R4");
        do_lookup(mk(TB, 20, 1), "R4");
        do_lookup(mk(TB, 20, 0), "R4");
        check_counts("R8");

        // R6 R13: single data flip, then the whole line is gone
        do_inject(1'b0, mk(TA, 3, 2), 36'h0_0000_0040);
        do_lookup(mk(TA, 3, 2), "R6");
        do_lookup(mk(TA, 3, 0), "R6");
        check_counts("R8");

        // R5 R13: tag flip
        do_fill(mk(TA, 40, 0), 32'h0F0F0F0F);
        do_fill(mk(TA, 40, 3), 32'hA5A5A5A5);
        do_inject(1'b1, mk(TA, 40, 0), 36'h0_0000_1000);
        do_lookup(mk(TA, 40, 3), "R5");
        do_lookup(mk(TA, 40, 0), "R5");
        check_counts("R8");

        // R7: four flips in distinct groups, parity-bit flips, tag multi-flip
        do_fill(mk(TB, 50, 0), 32'h13579BDF);
        do_inject(1'b0, mk(TB, 50, 0), 36'h0_0000_000F);
        do_lookup(mk(TB, 50, 0), "R7");
        do_fill(mk(TB, 50, 1), 32'h2468ACE0);
        do_inject(1'b0, mk(TB, 50, 1), 36'h0_0010_8420);
        do_lookup(mk(TB, 50, 1), "R7");
        do_fill(mk(TB, 50, 2), 32'h7777AAAA);
        do_inject(1'b0, mk(TB, 50, 2), 36'h2_0000_0000);
        do_lookup(mk(TB, 50, 2), "R7");
        do_fill(mk(TB, 51, 0), 32'h11112222);
        do_inject(1'b1, mk(TB, 51, 0), 36'h0_0000_000F);
        do_lookup(mk(TB, 51, 0), "R7");
        do_fill(mk(TB, 52, 0), 32'h33334444);
        do_inject(1'b1, mk(TB, 52, 0), 36'h0_0100_0000);
        do_lookup(mk(TB, 52, 0), "R7");
        check_counts("R8");

        // R10: lookup back to back with the restart on the same line
        do_fill(mk(TA, 9, 0), 32'h55550000);
        do_fill(mk(TA, 9, 1), 32'h55551111);
        do_inject(1'b0, mk(TA, 9, 1), 36'h0_0000_0080);
        do_lookup(mk(TA, 9, 1), "R10");
        do_lookup(mk(TA, 9, 0), "R10");
        check_counts("R8");

        // R9: saturate the tag counter
        for (int k = 0; k < 260; k++) begin
            do_fill(mk(TB, 5, 0), 32'h0000F00D);
            do_inject(1'b1, mk(TB, 5, 0), 36'h0_0000_0001);
            do_lookup(mk(TB, 5, 0), "R9");
        end
        check_counts("R9");
        // R9: clear in the same edge as a pending increment
        do_fill(mk(TB, 5, 0), 32'h0000F00D);
        do_inject(1'b1, mk(TB, 5, 0), 36'h0_0000_0001);
        do_lookup(mk(TB, 5, 0), "R9");
        do_clear();
        check_counts("R9");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R2", "scoreboard drained", 64'(sbq.size()), 0);
        done = 1;
        finish_run();
    end
endmodule